// File: doc/BRIEF.md
# Ping-Pong Infrared Run-Length Transmitter

This block drives up to two infrared emitters from a stream of run-length samples. Each sample is one byte. The top bit marks a mark (emitter active) or a gap (emitter dark). The low seven bits give a length counted in sample periods. The host writes these bytes into two holding slots. After filling slot 0, and slot 1 if it has more data, the host pulses `start`. Playback always begins at slot 0 and then alternates between the two slots.

A slot is consumed when its byte moves into the playback counter. At that moment the block raises a one-cycle interrupt. The slot can then be refilled while the sample it held is being played. If a sample ends and the slot whose turn is next holds no fresh byte, the block stops, darkens both outputs and sets a done flag.

During a mark the emitter output can be a square carrier or a steady level. The carrier's period and high time are counted in 500 ns ticks, and a polarity input inverts the waveform. A two-bit mask enables each emitter output on its own.

Top module: `irtx_top`

## Requirements
- R1: A `start` pulse begins playback only when the block is idle and slot 0 holds an unconsumed byte; otherwise it is ignored. Playback consumes slot 0 first and then alternates 1, 0, 1, ... .
- R2: In a sample byte, bit 7 = 1 means a mark and bit 7 = 0 a gap. Bits 6:0 are the length in sample periods (maximum 127). A length of 0 is played as 1.
- R3: One sample period lasts `samplePeriod` microseconds, which is 2·`samplePeriod`·`TICK_DIV` clock cycles. A `samplePeriod` value below 5 or above 127 is replaced by 50.
- R4: `txIrq` pulses high for exactly one cycle whenever a slot is consumed, including at the start. Two successive pulses are separated by the full duration of the sample loaded at the first of them.
- R5: When a sample ends and the next slot in turn has not been rewritten, `busy` falls and `done` rises. `done` stays set until the next accepted `start`.
- R6: During a gap both outputs are low. During a mark with `carPeriod` = 0 the enabled outputs stay high for the whole sample.
- R7: With `carPeriod` ≠ 0, a mark outputs a carrier of `carPeriod` ticks. It is high for the first `carHigh` ticks of each period, and a `carHigh` of 0 counts as 1. The phase restarts at the beginning of every sample.
- R8: `carInv` = 1 inverts the carrier waveform during marks.
- R9: `txMask` bit 0 enables `irOut[0]` and bit 1 enables `irOut[1]`. A disabled output stays low.
- R10: While the block is idle both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for a sample slot |
| wrSel | input | 1 | Slot index for the write |
| wrData | input | 8 | Sample byte: bit 7 mark flag, bits 6:0 length |
| start | input | 1 | Begin playback from slot 0 |
| samplePeriod | input | 8 | Sample period in microseconds |
| carPeriod | input | PRD_W | Carrier period in 500 ns ticks, 0 = no carrier |
| carHigh | input | PRD_W | Carrier high time in 500 ns ticks |
| carInv | input | 1 | Carrier polarity inversion |
| txMask | input | 2 | Per-emitter enable |
| irOut | output | 2 | Emitter drive outputs |
| txIrq | output | 1 | One-cycle slot-consumed pulse |
| busy | output | 1 | Playback in progress |
| done | output | 1 | Playback ended for lack of data |

## Verification
The assertions check the following on every cycle:
- an accepted start always finds slot 0 filled;
- the interrupt never lasts longer than one cycle;
- `done` and `busy` are never high together;
- the unit counter never reaches zero during playback;
- the outputs stay dark whenever the controller is idle.

Only the scenarios can show the timing properties. These include the exact length of each sample after period clamping and zero-length promotion, the alternation between slots, and the number of high cycles the carrier produces under each polarity, high width and mask setting. The scoreboard compares the interval between successive consume events, and the high-cycle count on each emitter, against values computed from the sample bytes.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int SMP_W = 8;
  localparam int CNT_W = SMP_W - 1;

  typedef struct packed {
    logic             load;
    logic             stop;
    logic [SMP_W-1:0] sample;
  } dpCmd_t;
endpackage

// File: rtl/irtx_ctrl.sv
module irtx_ctrl
  import irtx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [SMP_W-1:0] wrData,
  input  logic             start,
  input  logic             sampleEnd,
  output dpCmd_t           cmd,
  output logic             txIrq,
  output logic             busy,
  output logic             done
);
  logic [SMP_W-1:0] slotQ [2];
  logic [1:0]       full;
  logic             ptr;
  logic             startOk, nextLoad, endIdle, loadSel;

  assign startOk  = start & ~busy & full[0];
  assign nextLoad = sampleEnd & full[ptr];
  assign endIdle  = sampleEnd & ~full[ptr];
  assign loadSel  = startOk ? 1'b0 : ptr;

  always_comb begin
    cmd.load   = startOk | nextLoad;
    cmd.stop   = endIdle;
    cmd.sample = slotQ[loadSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      ptr   <= 1'b0;
      txIrq <= 1'b0;
    end else begin
      txIrq <= cmd.load;
      if (startOk) begin
        busy <= 1'b1;
        done <= 1'b0;
        ptr  <= 1'b1;
      end else if (nextLoad) begin
        ptr <= ~ptr;
      end else if (endIdle) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        full[i]  <= 1'b0;
        slotQ[i] <= '0;
      end else if (wrEn && wrSel == 1'(i)) begin
        full[i]  <= 1'b1;
        slotQ[i] <= wrData;
      end else if (cmd.load && loadSel == 1'(i)) begin
        full[i] <= 1'b0;
      end
    end
  end

  // R1: an accepted start always found slot 0 filled
  a_r1_start_needs_slot0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(full[0]));
  // R4: interrupt is a single-cycle pulse
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);
  // R5: done only while idle
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/irtx_datapath.sv
module irtx_datapath
  import irtx_pkg::*;
#(
  parameter int TICK_DIV   = 25,
  parameter int PRD_W      = 7,
  parameter int SP_MIN     = 5,
  parameter int SP_MAX     = 127,
  parameter int SP_DEFAULT = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [7:0]       samplePeriod,
  input  logic [PRD_W-1:0] carPeriod,
  input  logic [PRD_W-1:0] carHigh,
  input  logic             carInv,
  input  logic [1:0]       txMask,
  output logic             sampleEnd,
  output logic [1:0]       irOut
);
  localparam int UNIT_W = $clog2(SP_MAX * 2 * TICK_DIV + 1);
  localparam int CAR_W  = $clog2(((1 << PRD_W) - 1) * TICK_DIV + 1);

  logic [UNIT_W-1:0] spEff, unitLen, clkCnt;
  logic [CAR_W-1:0]  perClks, highClks, carCnt;
  logic [CNT_W-1:0]  remUnits, newCnt;
  logic              running, curPulse, carOn, wave, level, unitDone;

  always_comb begin
    if (samplePeriod < 8'(SP_MIN) || samplePeriod > 8'(SP_MAX))
      spEff = UNIT_W'(SP_DEFAULT);
    else
      spEff = UNIT_W'(samplePeriod);
    unitLen  = spEff * UNIT_W'(2 * TICK_DIV);
    perClks  = CAR_W'(carPeriod) * CAR_W'(TICK_DIV);
    highClks = ((carHigh == '0) ? CAR_W'(1) : CAR_W'(carHigh)) * CAR_W'(TICK_DIV);
    newCnt   = (cmd.sample[CNT_W-1:0] == '0) ? CNT_W'(1) : cmd.sample[CNT_W-1:0];
  end

  assign unitDone  = clkCnt == unitLen - UNIT_W'(1);
  assign sampleEnd = running & unitDone & (remUnits == CNT_W'(1));
  assign carOn     = carPeriod != '0;
  assign wave      = (carCnt < highClks) ^ carInv;
  assign level     = running & curPulse & (carOn ? wave : 1'b1);
  assign irOut     = txMask & {2{level}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      curPulse <= 1'b0;
      remUnits <= '0;
      clkCnt   <= '0;
      carCnt   <= '0;
    end else if (cmd.load) begin
      running  <= 1'b1;
      curPulse <= cmd.sample[SMP_W-1];
      remUnits <= newCnt;
      clkCnt   <= '0;
      carCnt   <= '0;
    end else if (cmd.stop) begin
      running  <= 1'b0;
      curPulse <= 1'b0;
    end else if (running) begin
      if (unitDone) begin
        clkCnt   <= '0;
        remUnits <= remUnits - CNT_W'(1);
      end else begin
        clkCnt <= clkCnt + UNIT_W'(1);
      end
      carCnt <= (carCnt >= perClks - CAR_W'(1)) ? '0 : carCnt + CAR_W'(1);
    end
  end

  // R2: a running sample never holds a zero unit count
  a_r2_units_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    running |-> remUnits != '0);
endmodule

// File: rtl/irtx_top.sv
module irtx_top
  import irtx_pkg::*;
#(
  parameter int TICK_DIV   = 25,
  parameter int PRD_W      = 7,
  parameter int SP_MIN     = 5,
  parameter int SP_MAX     = 127,
  parameter int SP_DEFAULT = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [7:0]       wrData,
  input  logic             start,
  input  logic [7:0]       samplePeriod,
  input  logic [PRD_W-1:0] carPeriod,
  input  logic [PRD_W-1:0] carHigh,
  input  logic             carInv,
  input  logic [1:0]       txMask,
  output logic [1:0]       irOut,
  output logic             txIrq,
  output logic             busy,
  output logic             done
);
  dpCmd_t cmd;
  logic   sampleEnd;

  irtx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .start(start), .sampleEnd(sampleEnd), .cmd(cmd), .txIrq(txIrq),
    .busy(busy), .done(done)
  );

  irtx_datapath #(
    .TICK_DIV(TICK_DIV), .PRD_W(PRD_W), .SP_MIN(SP_MIN),
    .SP_MAX(SP_MAX), .SP_DEFAULT(SP_DEFAULT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .samplePeriod(samplePeriod),
    .carPeriod(carPeriod), .carHigh(carHigh), .carInv(carInv),
    .txMask(txMask), .sampleEnd(sampleEnd), .irOut(irOut)
  );

  // R10: outputs dark whenever the controller is idle
  a_r10_dark_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> irOut == 2'b00);
endmodule

// File: tb/irtx_top_test.sv
module irtx_top_test;
  localparam int PRD_W = 7;

  logic clk = 0, rstN = 0;
  logic wrEn = 0, wrSel = 0, start = 0, carInv = 0;
  logic [7:0] wrData = 0, samplePeriod = 8'd5;
  logic [PRD_W-1:0] carPeriod = 0, carHigh = 0;
  logic [1:0] txMask = 0;
  logic [1:0] irOut;
  logic txIrq, busy, done;

  int total = 0, bad = 0;
  int cyc = 0, lastCyc = 0, hi0 = 0, hi1 = 0;
  bit inSeq = 0, prevDone = 0, finished = 0;
  int expIv[$], expH0[$], expH1[$];
  logic [7:0] seqQ[$];

  always #10 clk = ~clk;

  irtx_top #(.TICK_DIV(1), .PRD_W(PRD_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .start(start), .samplePeriod(samplePeriod), .carPeriod(carPeriod),
    .carHigh(carHigh), .carInv(carInv), .txMask(txMask), .irOut(irOut),
    .txIrq(txIrq), .busy(busy), .done(done)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2 R3 R6 R7 R8 R9: expected interval and per-emitter high count
  task automatic pushExp(logic [7:0] s);
    int sp, n, iv, cnt, h;
    bit lvl;
    sp  = (samplePeriod < 5 || samplePeriod > 127) ? 50 : int'(samplePeriod);
    n   = (s[6:0] == 0) ? 1 : int'(s[6:0]);
    iv  = n * 2 * sp;
    h   = (carHigh == 0) ? 1 : int'(carHigh);
    cnt = 0;
    for (int i = 0; i < iv; i++) begin
      if (!s[7]) lvl = 0;
      else if (carPeriod == 0) lvl = 1;
      else lvl = ((i % int'(carPeriod)) < h) ^ carInv;
      cnt += lvl;
    end
    expIv.push_back(iv);
    expH0.push_back(txMask[0] ? cnt : 0);
    expH1.push_back(txMask[1] ? cnt : 0);
  endtask

  // Monitor: events are consume pulses and the rise of done
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (txIrq || (done && !prevDone)) begin
        if (inSeq) begin
          if (expIv.size() == 0) begin
            total++; bad++;
            $display("FAIL R4: unexpected event actual=1 expected=0");
          end else begin
            chk("R3 R4 interval", cyc - lastCyc, expIv.pop_front());
            chk("R7 R9 emitter0 high", hi0, expH0.pop_front());
            chk("R8 R9 emitter1 high", hi1, expH1.pop_front());
          end
        end
        inSeq = txIrq;
        lastCyc = cyc;
        hi0 = 0; hi1 = 0;
      end
      hi0 += int'(irOut[0]);
      hi1 += int'(irOut[1]);
      prevDone = done;
    end
  end

  task automatic writeSlot(logic sel, logic [7:0] d);
    wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  // R1: preload slot 0 and 1, start, refill alternately on each interrupt
  task automatic runSeq();
    int n;
    n = seqQ.size();
    for (int k = 0; k < n && k < 2; k++) begin
      pushExp(seqQ[k]);
      writeSlot(k[0], seqQ[k]);
    end
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R1 busy after start", int'(busy), 1);
    chk("R5 done cleared by start", int'(done), 0);
    for (int k = 2; k < n; k++) begin
      while (!txIrq) @(negedge clk);
      pushExp(seqQ[k]);
      writeSlot(k[0], seqQ[k]);
    end
    while (!done) @(negedge clk);
    chk("R5 busy low at end", int'(busy), 0);
    chk("R10 outputs dark at end", int'(irOut), 0);
    repeat (3) @(negedge clk);
    chk("R4 queue drained", expIv.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R10 reset irOut", int'(irOut), 0);
    chk("R4 reset txIrq", int'(txIrq), 0);
    chk("R5 reset busy", int'(busy), 0);
    chk("R5 reset done", int'(done), 0);

    // R1: start with empty slot 0 is ignored
    txMask = 2'b11;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) begin
      chk("R1 start ignored busy", int'(busy), 0);
      chk("R1 start ignored irq", int'(txIrq), 0);
      @(negedge clk);
    end

    // R6 R2: no carrier, mixed marks/gaps, zero length
    samplePeriod = 8'd5; carPeriod = 0; carHigh = 0; carInv = 0; txMask = 2'b11;
    seqQ = '{8'h83, 8'h02, 8'h80, 8'h01};
    runSeq();

    // R7: carrier 10 ticks, 3 high, emitter 0 only
    carPeriod = 7'd10; carHigh = 7'd3; txMask = 2'b01;
    seqQ = '{8'h84, 8'h01, 8'h82};
    runSeq();

    // R8 R3: inverted, zero high width, period above range, emitter 1 only
    samplePeriod = 8'd200; carHigh = 7'd0; carInv = 1; txMask = 2'b10;
    seqQ = '{8'h81};
    runSeq();

    // R2: maximum length, gap of zero promoted to one unit
    samplePeriod = 8'd5; carPeriod = 0; carInv = 0; txMask = 2'b11;
    seqQ = '{8'hFF, 8'h7F, 8'h00};
    runSeq();

    // R3: period below range replaced by default
    samplePeriod = 8'd3; txMask = 2'b01;
    seqQ = '{8'h81, 8'h81};
    runSeq();

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule